// File: doc/BRIEF.md
# HDLC Transmit Framer with Underrun Abort

This block turns bytes written by a host into a bit-serial HDLC frame. The host pushes bytes into a small transmit FIFO through a write strobe. Each byte carries an end-of-message bit, and the FIFO reports full and empty in real time. On the line side, every cycle with `bit_en` high moves the serial output on by one bit. When the FIFO holds nothing, the line carries back-to-back `0x7E` flags. When a byte is waiting at a flag boundary, the flag just sent serves as the opening flag and the data bytes follow. Zeros are stuffed into the data and check field as needed, and the complemented CRC-16 and a closing flag end the frame.

If the FIFO runs dry at a byte boundary inside a frame, and the byte just sent was not marked as the last one, the frame cannot be finished. The block then sends an abort of eight ones without being asked and goes back to idle flags. It also sets an underrun event that stays set until the host reads it with `evt_rd`.

The controller is a five-state machine. `ST_IDLE` sends flags and takes the transition *start* to `ST_DATA` when the FIFO is not empty at the end of a flag. `ST_DATA` takes *next* (stays, popping another byte) when more data is queued. It takes *finish* to `ST_FCS_LO` after a byte marked end of message. It takes *underrun* to `ST_ABORT` when the FIFO is empty without that mark. `ST_FCS_LO` goes by *fcs* to `ST_FCS_HI`. `ST_FCS_HI` goes by *close* to `ST_IDLE`, and `ST_ABORT` goes by *recover* to `ST_IDLE`. Transitions are taken only on the last bit of a byte.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With the FIFO empty, the line repeats the flag byte 0x7E, bits sent least significant first (0,1,1,1,1,1,1,0), and after reset the first enabled bit is the first bit of such a flag.
- R2: A frame is an opening flag, the data bytes in write order with bit 0 first, then the ones' complement of the CRC-16 (reflected polynomial 0x8408, preset 0xFFFF, over the data bytes) sent low byte first, then a closing flag; the byte whose `wr_eom` was 1 is the last data byte.
- R3: Inside data and CRC bytes a 0 is inserted after every five consecutive 1 bits; flag and abort bytes are never stuffed.
- R4: When a data byte without the end-of-message mark finishes and the FIFO is empty, the block sends eight 1 bits (an abort), emits no check field or closing flag, and then returns to idle flags.
- R5: `evt_underrun` goes high in the cycle after an underrun, stays high until a cycle with `evt_rd` high, and is low in the cycle after that read unless a new underrun occurs in the read cycle.
- R6: `tx_full` is high exactly when the FIFO holds FIFO_DEPTH entries, updated in the same cycle as the write that fills it.
- R7: `tx_empty` is high exactly when the FIFO holds no entry; it is high after reset and goes low right after the first write.
- R8: A write while `tx_full` is high is dropped: it neither changes the FIFO nor appears on the line.
- R9: `tx_bit` changes only at a clock edge where `bit_en` was high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe into the transmit FIFO |
| wr_data | input | 8 | Byte to transmit |
| wr_eom | input | 1 | Marks the written byte as the last one of the frame |
| tx_full | output | 1 | FIFO full, real time |
| tx_empty | output | 1 | FIFO empty, real time |
| evt_rd | input | 1 | Host read of the underrun event; clears it |
| evt_underrun | output | 1 | Latched underrun event |
| bit_en | input | 1 | Advances the serial output by one bit |
| tx_bit | output | 1 | Serial line data |

## Verification
The assertions assume that the host keeps `wr_en`, `wr_data`, `wr_eom` and `evt_rd` stable within each cycle and drives `bit_en` as a plain per-cycle strobe. They also assume that the host writes only whole frames and never relies on a write made while the FIFO is full. The stimulus changes every input on the falling clock edge. It raises `bit_en` at most every other cycle, so the line has hold cycles that can be checked. It writes only while `tx_full` is low, except in the one scenario that deliberately overfills the FIFO with the line stopped. The underrun case is produced by leaving the end-of-message mark off the last queued byte.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'hFF;
    localparam logic [CRC_W-1:0]  CRC_PRESET = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_POLY   = 16'h8408;

    localparam int STUFF_RUN = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_ABORT
    } tx_state_t;

    function automatic logic is_stuffed(input tx_state_t st);
        return (st == ST_DATA) || (st == ST_FCS_LO) || (st == ST_FCS_HI);
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] din,
    input  logic             pop_req,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
    parameter int               DW   = 8,
    parameter int               CW   = 16,
    parameter logic [CW-1:0]    POLY = 16'h8408
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] crc_out
);
    always_comb begin
        logic [CW-1:0] c;
        c = crc_in;
        for (int i = 0; i < DW; i++) begin
            if (c[0] ^ data_in[i]) begin
                c = (c >> 1) ^ POLY;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/hdlc_tx_event.sv
module hdlc_tx_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_evt,
    output logic evt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (set_evt) begin
            evt_q <= 1'b1;
        end else if (rd_evt) begin
            evt_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_eom,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              evt_rd,
    output logic              evt_underrun,
    input  logic              bit_en,
    output logic              tx_bit
);
    localparam int ENTRY_W = BYTE_W + 1;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int ONES_W  = $clog2(STUFF_RUN + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [ONES_W-1:0] RUN_LIMIT = ONES_W'(STUFF_RUN);

    tx_state_t           st_q, st_d;
    logic [BYTE_W-1:0]   sh_q, nxt_byte;
    logic [CNT_W-1:0]    cnt_q;
    logic [ONES_W-1:0]   ones_q;
    logic [CRC_W-1:0]    crc_q, crc_seed, crc_nxt;
    logic                eom_q;
    logic                line_q;
    logic                stuff_now;
    logic                byte_end;
    logic                fifo_pop;
    logic                uf_set;
    logic [ENTRY_W-1:0]  fifo_dout;

    hdlc_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .din      ({wr_eom, wr_data}),
        .pop_req  (fifo_pop),
        .dout     (fifo_dout),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    assign crc_seed = (st_q == ST_IDLE) ? CRC_PRESET : crc_q;

    hdlc_crc16 #(
        .DW   (BYTE_W),
        .CW   (CRC_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_seed),
        .data_in (fifo_dout[BYTE_W-1:0]),
        .crc_out (crc_nxt)
    );

    hdlc_tx_event u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (uf_set),
        .rd_evt  (evt_rd),
        .evt_q   (evt_underrun)
    );

    // A stuffed zero takes a bit slot but does not consume a payload bit.
    assign stuff_now = (ones_q == RUN_LIMIT);
    assign byte_end  = bit_en && !stuff_now && (cnt_q == LAST_BIT);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions, evaluated only on the last bit of a byte.
    always_comb begin
        st_d     = st_q;
        fifo_pop = 1'b0;
        uf_set   = 1'b0;
        if (byte_end) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!tx_empty) begin
                        st_d     = ST_DATA;
                        fifo_pop = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (eom_q) begin
                        st_d = ST_FCS_LO;
                    end else if (!tx_empty) begin
                        fifo_pop = 1'b1;
                    end else begin
                        st_d   = ST_ABORT;
                        uf_set = 1'b1;
                    end
                end
                ST_FCS_LO: st_d = ST_FCS_HI;
                ST_FCS_HI: st_d = ST_IDLE;
                ST_ABORT:  st_d = ST_IDLE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // Byte loaded into the shifter for the state being entered.
    always_comb begin
        unique case (st_d)
            ST_DATA:   nxt_byte = fifo_dout[BYTE_W-1:0];
            ST_FCS_LO: nxt_byte = ~crc_q[BYTE_W-1:0];
            ST_FCS_HI: nxt_byte = ~crc_q[CRC_W-1:BYTE_W];
            ST_ABORT:  nxt_byte = ABORT_BYTE;
            default:   nxt_byte = FLAG_BYTE;
        endcase
    end

    // Output datapath: shifter, bit counter, run-of-ones counter, CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= FLAG_BYTE;
            cnt_q  <= '0;
            ones_q <= '0;
            line_q <= 1'b1;
            eom_q  <= 1'b0;
            crc_q  <= CRC_PRESET;
        end else if (bit_en) begin
            if (stuff_now) begin
                line_q <= 1'b0;
                ones_q <= '0;
            end else begin
                line_q <= sh_q[0];
                if (is_stuffed(st_q) && sh_q[0]) begin
                    ones_q <= ones_q + 1'b1;
                end else begin
                    ones_q <= '0;
                end
                if (cnt_q == LAST_BIT) begin
                    cnt_q <= '0;
                    sh_q  <= nxt_byte;
                    if (fifo_pop) begin
                        eom_q <= fifo_dout[ENTRY_W-1];
                        crc_q <= crc_nxt;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    sh_q  <= sh_q >> 1;
                end
            end
        end
    end

    assign tx_bit = line_q;

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_full,
    input logic tx_empty,
    input logic evt_rd,
    input logic evt_underrun,
    input logic bit_en,
    input logic tx_bit,
    input logic uf_set,
    input logic fifo_pop
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty)); // R6

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && wr_en && !fifo_pop) |=> tx_full); // R8

    AST_UNDERRUN_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set |-> tx_empty); // R4

    AST_UNDERRUN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set |=> evt_underrun); // R5

    AST_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_underrun && !evt_rd) |=> evt_underrun); // R5

    AST_EVENT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !uf_set) |=> !evt_underrun); // R5

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)); // R9

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .evt_rd       (evt_rd),
    .evt_underrun (evt_underrun),
    .bit_en       (bit_en),
    .tx_bit       (tx_bit),
    .uf_set       (uf_set),
    .fifo_pop     (fifo_pop)
);

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eom = 1'b0;
    logic       evt_rd = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_full, tx_empty, evt_underrun, tx_bit;

    always #4 clk = ~clk;

    hdlc_tx_framer #(.FIFO_DEPTH(DEPTH)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_eom       (wr_eom),
        .tx_full      (tx_full),
        .tx_empty     (tx_empty),
        .evt_rd       (evt_rd),
        .evt_underrun (evt_underrun),
        .bit_en       (bit_en),
        .tx_bit       (tx_bit)
    );

    int tests = 0;
    int fails = 0;
    int stab_err = 0;

    // Line decoder state.
    int         ones = 0;
    int         stuffed = 0;
    int         frames = 0;
    int         aborts = 0;
    int         bad_frames = 0;
    int         last_stuffed = 0;
    bit         dbits[$];
    bit         raw[$];
    logic [7:0] last_frame[$];

    // Stimulus and expectation.
    logic [7:0] pl[$];
    logic [7:0] exp_frame[$];
    int         exp_stuff = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic decode(input bit b);
        raw.push_back(b);
        if (b) begin
            ones++;
            dbits.push_back(1'b1);
            if (ones == 7) begin
                aborts++;
                dbits.delete();
                stuffed = 0;
            end
        end else begin
            if (ones == 5) begin
                stuffed++;
            end else if (ones == 6) begin
                repeat (7) if (dbits.size() > 0) void'(dbits.pop_back());
                if (dbits.size() > 0) begin
                    if (dbits.size() % 8 != 0) begin
                        bad_frames++;
                    end else begin
                        last_frame.delete();
                        for (int i = 0; i < dbits.size() / 8; i++) begin
                            logic [7:0] bv;
                            for (int j = 0; j < 8; j++) bv[j] = dbits[i*8 + j];
                            last_frame.push_back(bv);
                        end
                        last_stuffed = stuffed;
                        frames++;
                    end
                end
                dbits.delete();
                stuffed = 0;
            end else if (ones >= 7) begin
                dbits.delete();
                stuffed = 0;
            end else begin
                dbits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    // One enabled-or-not cycle followed by one cycle with bit_en low.
    task automatic pair(input bit do_bit, input bit do_wr, input logic [7:0] d, input bit e);
        logic prev;
        @(negedge clk);
        bit_en = do_bit; wr_en = do_wr; wr_data = d; wr_eom = e;
        @(posedge clk); #1;
        if (do_bit) decode(tx_bit);
        prev = tx_bit;
        @(negedge clk);
        bit_en = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        if (tx_bit !== prev) stab_err++;
    endtask

    task automatic build_exp();
        logic [15:0] c;
        int run;
        c = 16'hFFFF;
        exp_frame = pl;
        foreach (pl[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ pl[k][i]) c = (c >> 1) ^ 16'h8408;
                else c = c >> 1;
            end
        end
        c = ~c;
        exp_frame.push_back(c[7:0]);
        exp_frame.push_back(c[15:8]);
        exp_stuff = 0;
        run = 0;
        foreach (exp_frame[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (exp_frame[k][i]) begin
                    run++;
                    if (run == 5) begin exp_stuff++; run = 0; end
                end else begin
                    run = 0;
                end
            end
        end
    endtask

    // Write pl (if do_writes) while clocking bits, until a frame is decoded.
    task automatic run_frame(input bit do_writes, input bit with_eom, input int max_pairs);
        int idx = 0;
        int start = frames;
        int n = do_writes ? pl.size() : 0;
        for (int p = 0; p < max_pairs; p++) begin
            bit w;
            w = (idx < n) && !tx_full;
            if (w) begin
                pair(1'b1, 1'b1, pl[idx], with_eom && (idx == n - 1));
                idx++;
            end else begin
                pair(1'b1, 1'b0, 8'h00, 1'b0);
            end
            if (frames > start && idx == n) break;
        end
    endtask

    task automatic compare_frame(input string tag);
        int bad = -1;
        check(last_frame.size() == exp_frame.size(), {tag, " frame length"},
              last_frame.size(), exp_frame.size());
        if (last_frame.size() == exp_frame.size()) begin
            foreach (exp_frame[k]) if (bad < 0 && last_frame[k] !== exp_frame[k]) bad = k;
            if (bad >= 0)
                check(1'b0, {tag, " frame byte"}, last_frame[bad], exp_frame[bad]);
            else
                check(1'b1, {tag, " frame byte"}, 0, 0);
        end
    endtask

    task automatic t_reset();
        check(tx_empty === 1'b1, "R7 empty after reset", tx_empty, 1);
        check(tx_full === 1'b0, "R6 not full after reset", tx_full, 0);
        check(evt_underrun === 1'b0, "R5 event clear after reset", evt_underrun, 0);
    endtask

    task automatic t_idle();
        int bad = -1;
        raw.delete();
        repeat (32) pair(1'b1, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 32; i++) begin
            bit e;
            e = (8'h7E >> (i % 8)) & 1;
            if (bad < 0 && raw[i] != e) bad = i;
        end
        check(bad < 0, "R1 idle flag pattern (first bad bit index)", bad, -1);
        check(frames == 0, "R1 no frame while idle", frames, 0);
    endtask

    task automatic t_basic();
        int f0 = frames;
        pl = '{8'h12, 8'h34, 8'h56};
        build_exp();
        run_frame(1'b1, 1'b1, 200);
        check(frames == f0 + 1, "R2 one frame sent", frames, f0 + 1);
        compare_frame("R2 basic");
        check(tx_empty === 1'b1, "R7 empty after frame", tx_empty, 1);
    endtask

    task automatic t_stuff();
        pl = '{8'hFF, 8'hFF, 8'h3E, 8'h7E, 8'hF8};
        build_exp();
        run_frame(1'b1, 1'b1, 300);
        compare_frame("R3 ones-heavy");
        check(last_stuffed == exp_stuff, "R3 stuffed zero count", last_stuffed, exp_stuff);
        check(bad_frames == 0, "R3 no misaligned frames", bad_frames, 0);
    endtask

    task automatic t_long();
        pl.delete();
        for (int i = 0; i < 11; i++) pl.push_back(8'(i * 37 + 5));
        build_exp();
        run_frame(1'b1, 1'b1, 600);
        compare_frame("R2 long frame beyond FIFO depth");
    endtask

    task automatic t_underrun();
        int f0 = frames;
        int a0 = aborts;
        pl = '{8'hA5, 8'h0F};
        run_frame(1'b1, 1'b0, 120);
        check(aborts == a0 + 1, "R4 abort seen on line", aborts, a0 + 1);
        check(frames == f0, "R4 no frame completed", frames, f0);
        check(evt_underrun === 1'b1, "R5 event set after underrun", evt_underrun, 1);
        repeat (20) pair(1'b1, 1'b0, 8'h00, 1'b0);
        check(evt_underrun === 1'b1, "R5 event held until read", evt_underrun, 1);
        @(negedge clk); evt_rd = 1'b1;
        @(posedge clk); #1;
        check(evt_underrun === 1'b0, "R5 event cleared by read", evt_underrun, 0);
        @(negedge clk); evt_rd = 1'b0;
        pl = '{8'hC3};
        build_exp();
        run_frame(1'b1, 1'b1, 200);
        compare_frame("R4 frame after abort");
    endtask

    task automatic t_full();
        pl = '{8'h11, 8'h22, 8'h33, 8'h44};
        for (int i = 0; i < DEPTH; i++) begin
            pair(1'b0, 1'b1, pl[i], i == DEPTH - 1);
            if (i == 0) check(tx_empty === 1'b0, "R7 not empty after write", tx_empty, 0);
            if (i == DEPTH - 2) check(tx_full === 1'b0, "R6 not full one short", tx_full, 0);
        end
        check(tx_full === 1'b1, "R6 full at depth", tx_full, 1);
        pair(1'b0, 1'b1, 8'hAA, 1'b0);
        pair(1'b0, 1'b1, 8'hBB, 1'b1);
        check(tx_full === 1'b1, "R8 still full after dropped writes", tx_full, 1);
        build_exp();
        run_frame(1'b0, 1'b1, 300);
        compare_frame("R8 overfill writes dropped");
        check(tx_empty === 1'b1, "R8 nothing left queued", tx_empty, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_basic();
        t_stuff();
        t_long();
        t_underrun();
        t_full();
        check(stab_err == 0, "R9 line held while bit_en low", stab_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule